// File: doc/BRIEF.md
# Addressed RGBW Command Packet Decoder

This block sits behind a UART byte receiver on a multi-drop serial bus that several LED driver boards share. It takes received bytes one at a time and collects them into fixed-length command packets. Each packet has a command byte, a logical channel number and four colour intensities. Each intensity is two bytes, high byte first, in the order red, green, blue, white. There is no start marker. The block finds packet boundaries only by counting bytes, and it uses an inactivity timer to recover when a packet is cut short.

A finished packet is checked in two ways. The command byte must equal the set-colour code. The channel number must fall inside the window of eight logical channels that belongs to this board, and that window starts at a board offset set by a parameter. When both checks pass, the block writes the four intensities into the brightness register file of the output modulator, one write per clock. The channel number is converted to a base raw channel, and the colours are rearranged to match the order of the connector pins.

Top module: `rgbw_serial_decoder`

## Requirements
- R1: A packet is 10 bytes. Byte 0 is the command, byte 1 is the logical channel, and bytes 2..9 hold red, green, blue and white as 16-bit values, each sent high byte first.
- R2: A packet is written only when its command byte is 0x23. With any other command byte, no write is issued.
- R3: A packet is written only when its channel byte c satisfies OFS <= c <= OFS+7, where OFS is the board offset (default 8). With any other channel byte, no write is issued.
- R4: The base raw index is (c - OFS) * 4. Red is written to base+1, green to base+2, blue to base+3 and white to base+0.
- R5: The four writes of an accepted packet are presented on four consecutive cycles in the order red, green, blue, white. If the tenth byte is sampled at clock edge k, wr_en is high after edges k+1 through k+4.
- R6: After the tenth byte the byte position returns to zero, whether or not the packet was accepted, so the next byte is taken as a command byte.
- R7: If TIMEOUT_CYC clock edges pass with a partial packet held and no byte taken, the byte position returns to zero. A byte that arrives earlier continues the same packet.
- R8: A byte presented with rx_overrun high is discarded. It is not stored and does not advance the byte position.
- R9: While reset is held and right after it, wr_en is low.
- R10: wr_en stays low while a packet is being received. It is high only during the four-cycle write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Single-cycle strobe: rx_data holds a new byte |
| rx_overrun | input | 1 | The receiver overran on this byte; discard it |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Raw channel index to write |
| wr_value | output | 16 | 16-bit intensity to write |

## Verification
The bench probes both edges of the channel window (OFS-1, OFS, OFS+7, OFS+8). A window check that is off by one would either write a neighbouring board's channel or skip this board's last channel. It tests resynchronisation with a gap two cycles short of the timeout and another gap just past it. A wrong idle limit would either drop a slow packet or splice two packets together. Overrun bytes injected inside packets expose a framer that counts them. A bad-command packet followed by a good one shows whether framing survives a rejected packet. Every write is compared by index, value and cycle, which catches a colour mapping that is swapped, a byte order that is reversed, and a burst that is delayed or reordered.

// File: rtl/rgbw_dec_pkg.sv
package rgbw_dec_pkg;

   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned NUM_COL = 4;

   // order in which colours travel in a packet and are written out
   typedef enum logic [1:0] {
      COL_R = 2'd0,
      COL_G = 2'd1,
      COL_B = 2'd2,
      COL_W = 2'd3
   } col_e;

   // raw sub-channel slot of each colour inside a logical channel
   function automatic logic [1:0] col_slot(input col_e c);
      case (c)
         COL_R:   col_slot = 2'd1;
         COL_G:   col_slot = 2'd2;
         COL_B:   col_slot = 2'd3;
         default: col_slot = 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/rgbw_byte_framer.sv
module rgbw_byte_framer #(
   parameter int unsigned PKT_BYTES   = 10,
   parameter int unsigned TIMEOUT_CYC = 32000
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [rgbw_dec_pkg::BYTE_W-1:0]           rx_data,
   input  logic                                      rx_valid,
   input  logic                                      rx_overrun,
   output logic                                      pkt_done_o,
   output logic [PKT_BYTES*rgbw_dec_pkg::BYTE_W-1:0] pkt_o
);
   import rgbw_dec_pkg::*;

   localparam int unsigned CNT_W  = $clog2(PKT_BYTES);
   localparam int unsigned IDLE_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PKT_BYTES - 1);
   localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(TIMEOUT_CYC - 1);

   initial begin
      assert (PKT_BYTES >= 3) else $error("framer: packet too short");
      assert (TIMEOUT_CYC >= 2) else $error("framer: timeout too short");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic [IDLE_W-1:0] idle_q;
   logic              take;
   logic              last;
   logic              expire;

   assign take   = rx_valid & ~rx_overrun;
   assign last   = take && (cnt_q == CNT_LAST);
   assign expire = (cnt_q != '0) && !take && (idle_q == IDLE_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (take) begin
         cnt_q <= last ? '0 : cnt_q + 1'b1;
      end else if (expire) begin
         cnt_q <= '0;
      end
   end

   // idle timer only runs while a partial packet is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (take || (cnt_q == '0) || expire) begin
         idle_q <= '0;
      end else begin
         idle_q <= idle_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_done_o <= 1'b0;
      end else begin
         pkt_done_o <= last;
      end
   end

   for (genvar gi = 0; gi < PKT_BYTES; gi++) begin : g_slot
      logic [BYTE_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (take && (cnt_q == CNT_W'(gi))) begin
            slot_q <= rx_data;
         end
      end
      assign pkt_o[gi*BYTE_W +: BYTE_W] = slot_q;
   end

   // R8: an overrun byte leaves the position alone (unless the timer expires)
   p_overrun_dropped_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_overrun) |=> (cnt_q == $past(cnt_q)) || (cnt_q == '0));

   // R6: completion pulse is seen with the position already wrapped
   p_wrap_after_last_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done_o |-> (cnt_q == '0));

   // R7: an expired idle window clears the position
   p_timeout_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt_q != '0) && !take && (idle_q == IDLE_MAX)) |=> (cnt_q == '0));

   p_idle_bounded_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      idle_q <= IDLE_MAX);

endmodule

// File: rtl/rgbw_pkt_filter.sv
module rgbw_pkt_filter #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_LCH   = 8,
   parameter int unsigned BOARD_OFS = 8,
   parameter logic [7:0]  CMD_CODE  = 8'h23,
   localparam int unsigned VB        = DATA_W / rgbw_dec_pkg::BYTE_W,
   localparam int unsigned PKT_BYTES = 2 + rgbw_dec_pkg::NUM_COL * VB,
   localparam int unsigned LCH_W     = $clog2(NUM_LCH)
) (
   input  logic [PKT_BYTES*rgbw_dec_pkg::BYTE_W-1:0]           pkt_i,
   output logic                                                accept_o,
   output logic [LCH_W-1:0]                                    base_o,
   output logic [rgbw_dec_pkg::NUM_COL-1:0][DATA_W-1:0]        vals_o
);
   import rgbw_dec_pkg::*;

   initial begin
      assert (DATA_W % BYTE_W == 0 && DATA_W >= BYTE_W)
         else $error("filter: value width must be whole bytes");
      assert (NUM_LCH >= 2) else $error("filter: need at least two channels");
      assert (BOARD_OFS + NUM_LCH <= 256) else $error("filter: window past channel 255");
   end

   logic [BYTE_W-1:0] cmd_b;
   logic [BYTE_W-1:0] ch_b;
   logic              lo_ok;
   logic              hi_ok;

   assign cmd_b = pkt_i[0 +: BYTE_W];
   assign ch_b  = pkt_i[BYTE_W +: BYTE_W];

   if (BOARD_OFS == 0) begin : g_lo_free
      assign lo_ok = 1'b1;
   end else begin : g_lo_cmp
      assign lo_ok = (ch_b >= BYTE_W'(BOARD_OFS));
   end

   assign hi_ok    = ({1'b0, ch_b} < 9'(BOARD_OFS + NUM_LCH));
   assign accept_o = (cmd_b == CMD_CODE) && lo_ok && hi_ok;
   assign base_o   = LCH_W'(ch_b - BYTE_W'(BOARD_OFS));

   // colour c occupies bytes 2+c*VB .. 2+c*VB+VB-1, most significant first
   for (genvar c = 0; c < NUM_COL; c++) begin : g_col
      for (genvar j = 0; j < VB; j++) begin : g_byte
         assign vals_o[c][DATA_W-1-BYTE_W*j -: BYTE_W] =
            pkt_i[(2 + c*VB + j)*BYTE_W +: BYTE_W];
      end
   end

endmodule

// File: rtl/rgbw_write_seq.sv
module rgbw_write_seq #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LCH_W  = 3
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          load_i,
   input  logic [LCH_W-1:0]                              base_i,
   input  logic [rgbw_dec_pkg::NUM_COL-1:0][DATA_W-1:0]  vals_i,
   output logic                                          wr_en_o,
   output logic [LCH_W+1:0]                              wr_idx_o,
   output logic [DATA_W-1:0]                             wr_val_o
);
   import rgbw_dec_pkg::*;

   logic [NUM_COL-1:0][DATA_W-1:0] vals_q;
   logic [LCH_W-1:0]               base_q;
   logic                           active_q;
   col_e                           step_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vals_q   <= '0;
         base_q   <= '0;
         active_q <= 1'b0;
         step_q   <= COL_R;
      end else if (load_i) begin
         vals_q   <= vals_i;
         base_q   <= base_i;
         active_q <= 1'b1;
         step_q   <= COL_R;
      end else if (active_q) begin
         step_q <= col_e'(step_q + 2'd1);
         if (step_q == COL_W) begin
            active_q <= 1'b0;
         end
      end
   end

   assign wr_en_o  = active_q;
   assign wr_idx_o = {base_q, col_slot(step_q)};
   assign wr_val_o = vals_q[step_q];

   // R5: burst is unbroken until the white write
   p_burst_unbroken_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && step_q != COL_W && !load_i) |=> active_q);

   // R5: a burst always opens with red
   p_burst_starts_red_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active_q) |-> (step_q == COL_R));

   // R4: base is held for the whole burst
   p_base_stable_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && $past(active_q) && !$past(load_i)) |-> $stable(base_q));

endmodule

// File: rtl/rgbw_serial_decoder.sv
module rgbw_serial_decoder #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_LCH     = 8,
   parameter int unsigned BOARD_OFS   = 8,
   parameter logic [7:0]  CMD_CODE    = 8'h23,
   parameter int unsigned TIMEOUT_CYC = 32000,
   localparam int unsigned LCH_W      = $clog2(NUM_LCH),
   localparam int unsigned IDX_W      = LCH_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        rx_data,
   input  logic              rx_valid,
   input  logic              rx_overrun,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_value
);
   import rgbw_dec_pkg::*;

   localparam int unsigned VB        = DATA_W / BYTE_W;
   localparam int unsigned PKT_BYTES = 2 + NUM_COL * VB;

   logic                             pkt_done;
   logic [PKT_BYTES*BYTE_W-1:0]      pkt_bytes;
   logic                             pkt_ok;
   logic [LCH_W-1:0]                 pkt_base;
   logic [NUM_COL-1:0][DATA_W-1:0]   pkt_vals;

   rgbw_byte_framer #(
      .PKT_BYTES   (PKT_BYTES),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) framer_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_overrun (rx_overrun),
      .pkt_done_o (pkt_done),
      .pkt_o      (pkt_bytes)
   );

   rgbw_pkt_filter #(
      .DATA_W    (DATA_W),
      .NUM_LCH   (NUM_LCH),
      .BOARD_OFS (BOARD_OFS),
      .CMD_CODE  (CMD_CODE)
   ) filter_i (
      .pkt_i    (pkt_bytes),
      .accept_o (pkt_ok),
      .base_o   (pkt_base),
      .vals_o   (pkt_vals)
   );

   rgbw_write_seq #(
      .DATA_W (DATA_W),
      .LCH_W  (LCH_W)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (pkt_done && pkt_ok),
      .base_i   (pkt_base),
      .vals_i   (pkt_vals),
      .wr_en_o  (wr_en),
      .wr_idx_o (wr_idx),
      .wr_val_o (wr_value)
   );

   // R5 / R10: a burst only opens right after a completed packet
   p_burst_follows_packet_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> $past(pkt_done));

   // R2: wrong command never produces a write
   p_bad_cmd_silent_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && pkt_bytes[7:0] != CMD_CODE) |=> !wr_en);

   // R3: channel above the window never produces a write
   p_chan_above_silent_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_done && ({1'b0, pkt_bytes[15:8]} >= 9'(BOARD_OFS + NUM_LCH))) |=> !wr_en);

endmodule

// File: tb/rgbw_serial_decoder_tb_top.sv
module rgbw_serial_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int OFS        = 8;
   localparam int TMO        = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_overrun = 1'b0;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic [15:0] wr_value;

   rgbw_serial_decoder #(
      .BOARD_OFS   (OFS),
      .TIMEOUT_CYC (TMO)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_overrun (rx_overrun),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_value   (wr_value)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   int last_t = 0;
   int log_n  = 0;
   int log_idx [16];
   int log_val [16];
   int log_cyc [16];
   logic [7:0] pb [10];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && wr_en && log_n < 16) begin
         log_idx[log_n] = int'(wr_idx);
         log_val[log_n] = int'(wr_value);
         log_cyc[log_n] = cyc;
         log_n = log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic send_byte(input logic [7:0] b, input bit ovr);
      @(negedge clk);
      rx_data    = b;
      rx_valid   = 1'b1;
      rx_overrun = ovr;
      @(negedge clk);
      rx_valid   = 1'b0;
      rx_overrun = 1'b0;
      last_t     = cyc;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic void build(input logic [7:0] cmd, input logic [7:0] ch,
                                 input logic [15:0] r, input logic [15:0] g,
                                 input logic [15:0] b, input logic [15:0] w);
      pb[0] = cmd;     pb[1] = ch;
      pb[2] = r[15:8]; pb[3] = r[7:0];
      pb[4] = g[15:8]; pb[5] = g[7:0];
      pb[6] = b[15:8]; pb[7] = b[7:0];
      pb[8] = w[15:8]; pb[9] = w[7:0];
   endfunction

   // send bytes lo..hi of pb with a gap; optional overrun byte before index ovr_at
   task automatic send_range(input int lo, input int hi, input int gap, input int ovr_at);
      for (int k = lo; k <= hi; k++) begin
         if (k == ovr_at) send_byte(8'hA5, 1'b1);
         send_byte(pb[k], 1'b0);
         if (k != hi) idle(gap);
      end
   endtask

   function automatic int exp_idx(input int ch, input int col);
      exp_idx = (ch - OFS) * 4 + ((col == 3) ? 0 : col + 1);
   endfunction

   function automatic bit in_win(input logic [7:0] cmd, input int ch);
      in_win = (cmd == 8'h23) && (ch >= OFS) && (ch <= OFS + 7);
   endfunction

   task automatic expect_burst(input bit ok, input int ch, input logic [15:0] r,
                               input logic [15:0] g, input logic [15:0] b,
                               input logic [15:0] w, input string req);
      int ev [4];
      ev[0] = int'(r); ev[1] = int'(g); ev[2] = int'(b); ev[3] = int'(w);
      idle(6);
      if (!ok) begin
         check(log_n == 0, req, log_n, 0);
      end else begin
         check(log_n == 4, "R5", log_n, 4);
         for (int k = 0; k < 4 && k < log_n; k++) begin
            check(log_idx[k] == exp_idx(ch, k), "R4", log_idx[k], exp_idx(ch, k));
            check(log_val[k] == ev[k], "R1", log_val[k], ev[k]);
            check(log_cyc[k] == last_t + 1 + k, "R5", log_cyc[k], last_t + 1 + k);
            check(log_cyc[k] > last_t, "R10", log_cyc[k], last_t + 1);
         end
      end
      log_n = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
   end

   initial begin
      int unsigned seed_sink;
      seed_sink = $urandom(32'h1234);
      // R9: reset state
      idle(3);
      check(wr_en == 1'b0, "R9", int'(wr_en), 0);
      rst_n = 1'b1;
      idle(2);
      check(wr_en == 1'b0, "R9", int'(wr_en), 0);
      log_n = 0;

      // lowest channel of the window
      build(8'h23, 8'(OFS), 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
      send_range(0, 9, 1, -1);
      expect_burst(1, OFS, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, "R3");

      // highest channel of the window
      build(8'h23, 8'(OFS + 7), 16'h00FF, 16'hFF00, 16'h0001, 16'h8000);
      send_range(0, 9, 0, -1);
      expect_burst(1, OFS + 7, 16'h00FF, 16'hFF00, 16'h0001, 16'h8000, "R3");

      // just below and above the window
      build(8'h23, 8'(OFS - 1), 16'h1111, 16'h2222, 16'h3333, 16'h4444);
      send_range(0, 9, 0, -1);
      expect_burst(0, 0, 0, 0, 0, 0, "R3");
      build(8'h23, 8'(OFS + 8), 16'h1111, 16'h2222, 16'h3333, 16'h4444);
      send_range(0, 9, 0, -1);
      expect_burst(0, 0, 0, 0, 0, 0, "R3");

      // bad command, then a good packet right after (R2, R6)
      build(8'h24, 8'(OFS + 2), 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD);
      send_range(0, 9, 0, -1);
      expect_burst(0, 0, 0, 0, 0, 0, "R2");
      build(8'h23, 8'(OFS + 3), 16'h0102, 16'h0304, 16'h0506, 16'h0708);
      send_range(0, 9, 0, -1);
      expect_burst(1, OFS + 3, 16'h0102, 16'h0304, 16'h0506, 16'h0708, "R6");

      // overrun byte in the middle is dropped (R8)
      build(8'h23, 8'(OFS + 4), 16'hCAFE, 16'hBEEF, 16'hF00D, 16'h7777);
      send_range(0, 9, 1, 5);
      expect_burst(1, OFS + 4, 16'hCAFE, 16'hBEEF, 16'hF00D, 16'h7777, "R8");

      // gap inside the idle window keeps the packet (R7)
      build(8'h23, 8'(OFS + 5), 16'h4321, 16'h8765, 16'hCBA9, 16'h0FED);
      send_range(0, 4, 0, -1);
      idle(TMO - 2);
      send_range(5, 9, 0, -1);
      expect_burst(1, OFS + 5, 16'h4321, 16'h8765, 16'hCBA9, 16'h0FED, "R7");

      // gap past the idle window discards the partial packet (R7)
      build(8'h23, 8'(OFS + 1), 16'h9999, 16'h9999, 16'h9999, 16'h9999);
      send_range(0, 4, 0, -1);
      idle(TMO + 5);
      check(log_n == 0, "R7", log_n, 0);
      build(8'h23, 8'(OFS + 6), 16'h1357, 16'h2468, 16'h369C, 16'h48AD);
      send_range(0, 9, 0, -1);
      expect_burst(1, OFS + 6, 16'h1357, 16'h2468, 16'h369C, 16'h48AD, "R7");

      // constrained random packets
      for (int p = 0; p < 24; p++) begin
         logic [7:0]  cmd;
         int          ch;
         logic [15:0] vr, vg, vb, vw;
         int          ovr_at;
         cmd = 8'h23;
         if ($urandom_range(0, 4) == 0) begin
            cmd = 8'($urandom_range(0, 255));
            if (cmd == 8'h23) cmd = 8'h22;
         end
         ch = int'($urandom_range(0, 20));
         vr = 16'($urandom); vg = 16'($urandom);
         vb = 16'($urandom); vw = 16'($urandom);
         ovr_at = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 9)) : -1;
         build(cmd, 8'(ch), vr, vg, vb, vw);
         send_range(0, 9, int'($urandom_range(0, 3)), ovr_at);
         expect_burst(in_win(cmd, ch), ch, vr, vg, vb, vw,
                      (cmd != 8'h23) ? "R2" : "R3");
      end

      report();
   end

endmodule